// File: doc/BRIEF.md
# Interrupt CPU Interface Prioritizer

This block sits between an interrupt distributor and one processor. Each cycle the distributor presents its best candidate interrupt, an ID and an 8-bit priority in which a lower value means more urgent. The block decides whether to raise the interrupt request line to the processor. It bases that decision on four things: an interface enable, a priority mask, a binary point that splits the priority into group and sub-priority bits, and a stack of running priorities for nested handlers.

Software reaches the block through a small register port. Register reads are combinational on `rdata_o`, and any side effect takes place at the clock edge that ends the access.

Register map (word address on `addr_i`):
- 0: control, bit 0 is the enable.
- 1: priority mask, bits [7:0].
- 2: binary point, bits [2:0].
- 3: acknowledge, read only, returns the ID in bits [9:0].
- 4: end of interrupt, write only, takes the ID from bits [9:0].
- 5: highest pending, read only, returns the ID in bits [9:0].
- 6: running priority, read only, bits [7:0].

Reads of any other address return 0. The spurious ID is 1023.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset `irq_o` and `err_o` are low, the enable is 0, the mask reads 0xFF, the binary point reads 0 and the running priority reads 0xFF.
- R2: A candidate can raise `irq_o` only when its priority is numerically lower than the mask; a priority equal to or above the mask never raises it.
- R3: When a candidate qualifies, an acknowledge read returns its ID and pulses `ack_o` with `ack_id_o` set to that ID during the access. After the access it pushes the candidate's full priority onto the stack, so the running priority then reads that value.
- R4: An acknowledge read returns 1023 and changes no state when the interface is disabled, when no candidate is valid, or when the candidate does not qualify.
- R5: A highest-pending read returns the candidate ID, or 1023 when no candidate is valid. It does not acknowledge, so the running priority and `irq_o` are unchanged afterwards.
- R6: With binary point n, the priority bits above bit n form the group priority. While a handler is running, a candidate preempts only if its group priority is strictly lower than the running group priority.
- R7: A candidate whose group priority equals the running one never raises `irq_o`, even when its sub-priority is lower. With binary point 7 no candidate preempts a running handler; with an empty stack any unmasked candidate is signalled.
- R8: An end-of-interrupt write whose ID matches the top of the stack pops it, and the running priority returns to the previous entry, or to 0xFF when the stack becomes empty.
- R9: An end-of-interrupt write whose ID does not match the top entry, or that arrives with an empty stack, leaves the stack unchanged and sets `err_o`, which stays set until reset.
- R10: The stack holds 8 entries. While it is full, `irq_o` stays low and an acknowledge read returns 1023.
- R11: Clearing the enable bit forces `irq_o` low regardless of the candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cand_valid_i | input | 1 | Distributor presents a candidate |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid during the access |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_o | output | 1 | Acknowledge pulse to the distributor |
| ack_id_o | output | 10 | ID being acknowledged |
| err_o | output | 1 | Sticky out-of-order end-of-interrupt flag |

## Verification
The prioritizer is driven with candidates just below, at and above the mask, which separates a strict comparison from an inclusive one. Pairs of candidates that share a group but differ in sub-priority, taken under binary points 0, 3 and 7, show that only the group bits decide preemption and that an empty stack bypasses the group test. Nested acknowledges followed by end-of-interrupt writes in correct and wrong order tell a real pop apart from a mismatch. A run of eight acknowledges that fills the stack checks the full boundary, and disabled and no-candidate cases confirm the spurious path.

// File: rtl/irq_cpu_if_pkg.sv
package irq_cpu_if_pkg;
  localparam int unsigned ID_W   = 10;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned BP_W   = $clog2(PRIO_W);
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ID_W-1:0] SPURIOUS_ID = '1;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_MASK = 3'd1,
    REG_BPT  = 3'd2,
    REG_ACK  = 3'd3,
    REG_EOI  = 3'd4,
    REG_HIGH = 3'd5,
    REG_RUN  = 3'd6
  } reg_addr_e;

  // bits above position bp are group priority
  function automatic logic [PRIO_W-1:0] group_of(logic [PRIO_W-1:0] prio,
                                                 logic [BP_W-1:0] bp);
    logic [PRIO_W:0] m;
    m = {(PRIO_W+1){1'b1}} << (int'(bp) + 1);
    return prio & m[PRIO_W-1:0];
  endfunction
endpackage

// File: rtl/irq_prio_cmp.sv
module irq_prio_cmp
  import irq_cpu_if_pkg::*;
(
  input  logic              enable_i,
  input  logic              cand_valid_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [PRIO_W-1:0] mask_i,
  input  logic [BP_W-1:0]   bp_i,
  input  logic [PRIO_W-1:0] run_prio_i,
  input  logic              run_empty_i,
  input  logic              run_full_i,
  output logic              qualify_o
);
  logic [PRIO_W-1:0] cand_grp, run_grp;
  logic              below_mask, preempts;

  always_comb begin
    cand_grp   = group_of(cand_prio_i, bp_i);
    run_grp    = group_of(run_prio_i, bp_i);
    below_mask = cand_prio_i < mask_i;
    preempts   = run_empty_i || (cand_grp < run_grp);
    qualify_o  = enable_i && cand_valid_i && below_mask && preempts && !run_full_i;
  end

  always_comb begin
    if (qualify_o) a_r2_below_mask: assert (cand_prio_i < mask_i);
  end
endmodule

// File: rtl/irq_run_stack.sv
module irq_run_stack
  import irq_cpu_if_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ID_W-1:0]   push_id_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              pop_i,
  output logic [ID_W-1:0]   top_id_o,
  output logic [PRIO_W-1:0] top_prio_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  top_idx, wr_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_idx = IDX_W'(cnt_q - 1'b1);
  assign wr_idx  = IDX_W'(cnt_q);

  assign top_id_o   = empty_o ? SPURIOUS_ID : id_q[top_idx];
  assign top_prio_o = empty_o ? '1 : prio_q[top_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_q[g]   <= '0;
        prio_q[g] <= '0;
      end else if (push_i && !full_o && wr_idx == IDX_W'(g)) begin
        id_q[g]   <= push_id_i;
        prio_q[g] <= push_prio_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (push_i && !full_o)   cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty_o)   cnt_q <= cnt_q - 1'b1;
  end

  a_r10_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r8_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r8_pop_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r10_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irq_cpu_if_pkg::*;
#(
  parameter int unsigned STACK_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              ack_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              err_o
);
  logic              enable_q, err_q;
  logic [PRIO_W-1:0] mask_q;
  logic [BP_W-1:0]   bp_q;
  logic [ID_W-1:0]   top_id;
  logic [PRIO_W-1:0] top_prio;
  logic              empty, full, qualify;
  logic              rd, wr, do_push, eoi_wr, eoi_hit;
  logic [ID_W-1:0]   eoi_id;

  assign rd      = req_i && !we_i;
  assign wr      = req_i && we_i;
  assign do_push = rd && addr_i == REG_ACK && qualify;
  assign eoi_wr  = wr && addr_i == REG_EOI;
  assign eoi_id  = wdata_i[ID_W-1:0];
  assign eoi_hit = eoi_wr && !empty && eoi_id == top_id;

  irq_prio_cmp u_cmp (
    .enable_i    (enable_q),
    .cand_valid_i(cand_valid_i),
    .cand_prio_i (cand_prio_i),
    .mask_i      (mask_q),
    .bp_i        (bp_q),
    .run_prio_i  (top_prio),
    .run_empty_i (empty),
    .run_full_i  (full),
    .qualify_o   (qualify)
  );

  irq_run_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (do_push),
    .push_id_i  (cand_id_i),
    .push_prio_i(cand_prio_i),
    .pop_i      (eoi_hit),
    .top_id_o   (top_id),
    .top_prio_o (top_prio),
    .empty_o    (empty),
    .full_o     (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= 1'b0;
      mask_q   <= '1;
      bp_q     <= '0;
      err_q    <= 1'b0;
    end else begin
      if (wr && addr_i == REG_CTRL) enable_q <= wdata_i[0];
      if (wr && addr_i == REG_MASK) mask_q   <= wdata_i[PRIO_W-1:0];
      if (wr && addr_i == REG_BPT)  bp_q     <= wdata_i[BP_W-1:0];
      if (eoi_wr && !eoi_hit)       err_q    <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        REG_CTRL: rdata_o[0]          = enable_q;
        REG_MASK: rdata_o[PRIO_W-1:0] = mask_q;
        REG_BPT:  rdata_o[BP_W-1:0]   = bp_q;
        REG_ACK:  rdata_o[ID_W-1:0]   = qualify ? cand_id_i : SPURIOUS_ID;
        REG_HIGH: rdata_o[ID_W-1:0]   = cand_valid_i ? cand_id_i : SPURIOUS_ID;
        REG_RUN:  rdata_o[PRIO_W-1:0] = top_prio;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o    = qualify;
  assign ack_o    = do_push;
  assign ack_id_o = do_push ? cand_id_i : SPURIOUS_ID;
  assign err_o    = err_q;

  a_r11_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_q |-> !irq_o);
  a_r3_push_records_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> top_prio == $past(cand_prio_i));
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r10_full_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !irq_o);
endmodule

// File: tb/irq_cpu_if_tb_top.sv
module irq_cpu_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = 8'hFF;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, ack, err;
  logic [9:0]  ack_id;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_cpu_if dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cand_valid_i(cand_valid), .cand_id_i(cand_id), .cand_prio_i(cand_prio),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .ack_o(ack), .ack_id_o(ack_id), .err_o(err)
  );

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  // returns data and ack seen during the access
  task automatic rd_reg(logic [2:0] a, output logic [31:0] d, output logic a_seen);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1;
    d = rdata; a_seen = ack;
    @(negedge clk);
    req = 0;
  endtask

  task automatic set_cand(logic v, logic [9:0] id, logic [7:0] p);
    @(negedge clk);
    cand_valid = v; cand_id = id; cand_prio = p;
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic a;
    check("R1 irq", irq, 0);
    check("R1 err", err, 0);
    rd_reg(3'd0, d, a); check("R1 enable", d, 0);
    rd_reg(3'd1, d, a); check("R1 mask", d, 32'hFF);
    rd_reg(3'd2, d, a); check("R1 bp", d, 0);
    rd_reg(3'd6, d, a); check("R1 running", d, 32'hFF);
  endtask

  task automatic t_mask;
    wr_reg(3'd0, 1);
    set_cand(1, 10'd40, 8'h80); check("R2 below default mask", irq, 1);
    set_cand(1, 10'd40, 8'hFF); check("R2 equal mask", irq, 0);
    wr_reg(3'd1, 32'h80);
    set_cand(1, 10'd40, 8'h80); check("R2 at mask", irq, 0);
    set_cand(1, 10'd40, 8'h7F); check("R2 just below mask", irq, 1);
    wr_reg(3'd1, 32'hFF);
  endtask

  task automatic t_high_and_nest;
    logic [31:0] d; logic a;
    set_cand(1, 10'd40, 8'h80);
    rd_reg(3'd5, d, a); check("R5 high id", d, 40);
    check("R5 no ack", a, 0);
    rd_reg(3'd6, d, a); check("R5 running unchanged", d, 32'hFF);
    check("R5 irq still up", irq, 1);
    rd_reg(3'd3, d, a); check("R3 ack id", d, 40);
    check("R3 ack pulse", a, 1);
    rd_reg(3'd6, d, a); check("R3 running", d, 32'h80);
    set_cand(1, 10'd41, 8'h80); check("R7 same prio no preempt", irq, 0);
    set_cand(1, 10'd41, 8'h81); check("R7 same group bp0", irq, 0);
    set_cand(1, 10'd41, 8'h7E); check("R6 lower group preempts", irq, 1);
    rd_reg(3'd3, d, a); check("R3 nested ack", d, 41);
    rd_reg(3'd6, d, a); check("R3 nested running", d, 32'h7E);
    wr_reg(3'd4, 40);
    check("R9 err set", err, 1);
    rd_reg(3'd6, d, a); check("R9 stack unchanged", d, 32'h7E);
    wr_reg(3'd4, 41);
    rd_reg(3'd6, d, a); check("R8 pop to previous", d, 32'h80);
    check("R9 err sticky", err, 1);
    wr_reg(3'd4, 40);
    rd_reg(3'd6, d, a); check("R8 pop to empty", d, 32'hFF);
  endtask

  task automatic t_binary_point;
    logic [31:0] d; logic a;
    wr_reg(3'd2, 3);
    set_cand(1, 10'd50, 8'h45);
    rd_reg(3'd3, d, a); check("R3 ack bp3", d, 50);
    set_cand(1, 10'd51, 8'h41); check("R7 same group bp3", irq, 0);
    set_cand(1, 10'd51, 8'h3F); check("R6 lower group bp3", irq, 1);
    wr_reg(3'd2, 7);
    set_cand(1, 10'd51, 8'h00); check("R7 bp7 no preempt", irq, 0);
    wr_reg(3'd4, 50);
    check("R7 bp7 empty stack signals", irq, 1);
    wr_reg(3'd2, 0);
  endtask

  task automatic t_spurious;
    logic [31:0] d; logic a;
    wr_reg(3'd0, 0);
    set_cand(1, 10'd60, 8'h10); check("R11 disabled irq", irq, 0);
    rd_reg(3'd3, d, a); check("R4 disabled ack", d, 1023);
    check("R4 no ack pulse", a, 0);
    rd_reg(3'd6, d, a); check("R4 running unchanged", d, 32'hFF);
    wr_reg(3'd0, 1);
    check("R11 re-enabled", irq, 1);
    set_cand(0, 10'd60, 8'h10);
    rd_reg(3'd3, d, a); check("R4 no candidate ack", d, 1023);
    rd_reg(3'd5, d, a); check("R5 no candidate high", d, 1023);
  endtask

  task automatic t_depth;
    logic [31:0] d; logic a;
    for (int i = 0; i < 8; i++) begin
      set_cand(1, 10'(100 + i), 8'(8'h80 - 8'(i * 16)));
      rd_reg(3'd3, d, a); check("R10 fill ack", d, 100 + i);
    end
    rd_reg(3'd6, d, a); check("R10 full running", d, 32'h10);
    set_cand(1, 10'd120, 8'h00); check("R10 full no irq", irq, 0);
    rd_reg(3'd3, d, a); check("R10 full ack spurious", d, 1023);
    for (int i = 7; i >= 0; i--) wr_reg(3'd4, 100 + i);
    rd_reg(3'd6, d, a); check("R8 unwound", d, 32'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_mask();
    t_high_and_nest();
    t_binary_point();
    t_spurious();
    t_depth();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule